// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Loader

This block keeps the two threshold offsets used by a deep first-in first-out buffer's partial flags. The almost-empty offset (n) and the almost-full offset (m) are each held as a low part of 9 bits and a high part of `ADDR_W-9` bits. Together the four parts form a ring of registers. A single 9-bit data port on the write clock loads the ring, and the read clock returns the stored values on a 9-bit read-back bus. Both kinds of access are gated by an active-low load pin.

The load pin does two jobs. The level it holds while reset is asserted selects the mode. If the pin is held low during reset, the block is in programming mode and the ring can be accessed. If the pin is held high during reset, it acts as a second write enable for the surrounding buffer, and this block ignores all accesses and keeps its default values.

In programming mode, separate position counters on the write side and the read side step through the ring as accesses are made. Each counter keeps its position while the load pin is high, so a partial update picks up at the next register when the pin goes low again. The combined n and m values are driven out continuously to the flag logic.

Top module: `ofs_load_seq`

## Requirements
- R1: While `rstN` is low, a rising `wrClk` edge returns both low parts to 7 and both high parts to 0, so `offN` = `offM` = 7. A rising `rdClk` edge during reset clears `rdData` to 0. Both position counters return to the empty-low slot.
- R2: In programming mode, each rising `wrClk` edge with `ldN` low and `wrEn1N` low writes `wrData` into the next slot of the ring. The slot order is index 0 empty-low, 1 empty-high, 2 full-low, 3 full-high. The outputs are formed as `offN = {slot1, slot0}` and `offM = {slot3, slot2}`.
- R3: The write that follows a write to slot 3 goes to slot 0, so the fifth write wraps around to the empty-low register.
- R4: Write and read positions persist while `ldN` is high. The next load access continues at the slot after the last one accessed.
- R5: In programming mode, each rising `rdClk` edge with `ldN`, `rdEn1N` and `rdEn2N` all low loads `rdData` with the next slot in the same order. The read counter is independent of the write counter.
- R6: A high slot is `ADDR_W-9` bits wide. The upper `wrData` bits written to a high slot are dropped, and the slot reads back with those bits as zero.
- R7: A `wrClk` edge with `ldN` high or with `wrEn1N` high neither changes any slot nor advances the write position.
- R8: A `rdClk` edge with `rdEn1N` or `rdEn2N` high, or with `ldN` high, leaves `rdData` unchanged and does not advance the read position.
- R9: When `ldN` was high during reset, all writes and reads are ignored. `offN` and `offM` stay at 7 and `rdData` stays at 0.
- R10: `rdData` changes only on the `rdClk` edge that performs the read, which gives one edge of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Synchronous reset, active low, seen by both clocks |
| ldN | input | 1 | Load pin; its level during reset selects the mode, and afterwards low gates accesses to the ring |
| wrEn1N | input | 1 | Write enable, active low |
| rdEn1N | input | 1 | First read enable, active low |
| rdEn2N | input | 1 | Second read enable, active low |
| wrData | input | 9 | Value to be written into the selected slot |
| offN | output | ADDR_W | Almost-empty offset n |
| offM | output | ADDR_W | Almost-full offset m |
| rdData | output | 9 | Read-back value of the selected slot |

## Verification
The write path and the read path both step through the same ring of registers. A load through one path can coincide with a position step in the other, and a write with `ldN` low can fall on the same cycle as a normal buffer write or an idle cycle. The bench interleaves wrapping write sequences with `ldN` breaks and disabled-enable cycles, then reads the ring back through a read counter that it models separately. Every `offN`, `offM` and `rdData` value is judged against ring contents that the bench computes arithmetically, including the masking of the high slots and the wrap after the fourth slot.

// File: rtl/ofs_load_pkg.sv
package ofs_load_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SEL_W = $clog2(NUM_SLOTS);
  localparam int DATA_W = 9;

  typedef struct packed {
    logic             wrStb;
    logic [SEL_W-1:0] wrSel;
    logic             rdStb;
    logic [SEL_W-1:0] rdSel;
  } ofsStrobes_t;
endpackage

// File: rtl/ofs_load_ctrl.sv
module ofs_load_ctrl
  import ofs_load_pkg::*;
(
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        ldN,
  input  logic        wrEn1N,
  input  logic        rdEn1N,
  input  logic        rdEn2N,
  output ofsStrobes_t stb
);
  logic             progModeW;
  logic             progModeR;
  logic [SEL_W-1:0] wrSel;
  logic [SEL_W-1:0] rdSel;
  logic             wrStb;
  logic             rdStb;

  // mode is captured in each clock domain while reset is held
  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      progModeW <= ~ldN;
      wrSel     <= '0;
    end else if (wrStb) begin
      wrSel <= wrSel + 1'b1;
    end
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      progModeR <= ~ldN;
      rdSel     <= '0;
    end else if (rdStb) begin
      rdSel <= rdSel + 1'b1;
    end
  end

  always_comb begin
    wrStb = rstN && progModeW && !ldN && !wrEn1N;
    rdStb = rstN && progModeR && !ldN && !rdEn1N && !rdEn2N;
    stb.wrStb = wrStb;
    stb.wrSel = wrSel;
    stb.rdStb = rdStb;
    stb.rdSel = rdSel;
  end

  // R3, R4: write position advances by one (wrapping) per access, else holds
  assert_wr_step_R3: assert property (@(posedge wrClk) disable iff (!rstN)
    wrStb |=> wrSel == SEL_W'($past(wrSel) + 1'b1));
  assert_wr_hold_R4: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrStb |=> $stable(wrSel));
  // R5, R8: read position behaves the same on the read clock
  assert_rd_step_R5: assert property (@(posedge rdClk) disable iff (!rstN)
    rdStb |=> rdSel == SEL_W'($past(rdSel) + 1'b1));
  assert_rd_hold_R8: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdStb |=> $stable(rdSel));
endmodule

// File: rtl/ofs_load_data.sv
module ofs_load_data
  import ofs_load_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  ofsStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] offN,
  output logic [ADDR_W-1:0] offM,
  output logic [DATA_W-1:0] rdData
);
  localparam int MSB_W = ADDR_W - DATA_W;
  localparam logic [DATA_W-1:0] LSB_DEFAULT = DATA_W'(7);
  localparam logic [DATA_W-1:0] MSB_MASK = DATA_W'((1 << MSB_W) - 1);

  logic [NUM_SLOTS-1:0][DATA_W-1:0] regView;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    if (g % 2 == 0) begin : gLow
      logic [DATA_W-1:0] val;
      always_ff @(posedge wrClk) begin
        if (!rstN) val <= LSB_DEFAULT;
        else if (stb.wrStb && stb.wrSel == SEL_W'(g)) val <= wrData;
      end
      assign regView[g] = val;
    end else begin : gHigh
      logic [MSB_W-1:0] val;
      always_ff @(posedge wrClk) begin
        if (!rstN) val <= '0;
        else if (stb.wrStb && stb.wrSel == SEL_W'(g)) val <= wrData[MSB_W-1:0];
      end
      assign regView[g] = {{(DATA_W-MSB_W){1'b0}}, val};
    end
  end

  assign offN = {regView[1][MSB_W-1:0], regView[0]};
  assign offM = {regView[3][MSB_W-1:0], regView[2]};

  always_ff @(posedge rdClk) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdStb) rdData <= regView[stb.rdSel];
  end

  // R2, R6: a write lands in the selected slot, high slots masked
  assert_wr_lands_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    stb.wrStb |=> regView[$past(stb.wrSel)] ==
      ($past(stb.wrSel[0]) ? ($past(wrData) & MSB_MASK) : $past(wrData)));
  // R7: no strobe, no change
  assert_no_write_R7: assert property (@(posedge wrClk) disable iff (!rstN)
    !stb.wrStb |=> $stable(regView));
  // R8: read-back holds without a read strobe
  assert_rd_hold_R8b: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.rdStb |=> $stable(rdData));
  // R6: high slots never carry bits above their width
  assert_msb_clear_R6: assert property (@(posedge wrClk) disable iff (!rstN)
    ((regView[1] | regView[3]) & ~MSB_MASK) == '0);
endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_load_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              wrEn1N,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic [8:0]        wrData,
  output logic [ADDR_W-1:0] offN,
  output logic [ADDR_W-1:0] offM,
  output logic [8:0]        rdData
);
  ofsStrobes_t stb;

  ofs_load_ctrl uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .ldN(ldN),
    .wrEn1N(wrEn1N), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .stb(stb)
  );

  ofs_load_data #(.ADDR_W(ADDR_W)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrData(wrData), .offN(offN), .offM(offM), .rdData(rdData)
  );
endmodule

// File: tb/sim_ofs_load_seq.sv
module sim_ofs_load_seq;
  localparam int ADDR_W = 14;
  localparam int MSB_MOD = 1 << (ADDR_W - 9);

  logic wrClk = 0, rdClk = 0, rstN = 0, ldN = 1, wrEn1N = 1, rdEn1N = 1, rdEn2N = 1;
  logic [8:0] wrData = 0;
  logic [ADDR_W-1:0] offN, offM;
  logic [8:0] rdData;

  int compared = 0, mismatched = 0;
  int expSlot[4];
  int expWrSel, expRdSel, expRd;
  bit progMode;

  ofs_load_seq #(.ADDR_W(ADDR_W)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .ldN(ldN), .wrEn1N(wrEn1N),
    .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .wrData(wrData),
    .offN(offN), .offM(offM), .rdData(rdData)
  );

  always #4 wrClk = ~wrClk;
  initial begin #3; forever #4 rdClk = ~rdClk; end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkOffsets(string req);
    check(req, int'(offN), expSlot[1] * 512 + expSlot[0]);
    check(req, int'(offM), expSlot[3] * 512 + expSlot[2]);
  endtask

  task automatic doReset(bit ldLevel);
    rstN = 0; ldN = ldLevel; wrEn1N = 1; rdEn1N = 1; rdEn2N = 1;
    repeat (3) @(posedge wrClk);
    repeat (2) @(posedge rdClk);
    @(negedge wrClk);
    rstN = 1; ldN = 1;
    expSlot = '{7, 0, 7, 0};
    expWrSel = 0; expRdSel = 0; expRd = 0;
    progMode = !ldLevel;
  endtask

  task automatic doWrite(bit l, bit w, int d, string req);
    @(negedge wrClk);
    ldN = l; wrEn1N = w; wrData = 9'(d);
    @(posedge wrClk); #1;
    if (progMode && !l && !w) begin
      expSlot[expWrSel] = (expWrSel % 2) ? (d % MSB_MOD) : (d % 512);
      expWrSel = (expWrSel + 1) % 4;
    end
    ldN = 1; wrEn1N = 1;
    checkOffsets(req);
  endtask

  task automatic doRead(bit l, bit r1, bit r2, string req);
    @(negedge rdClk);
    ldN = l; rdEn1N = r1; rdEn2N = r2;
    check("R10", int'(rdData), expRd);  // nothing changes before the edge
    @(posedge rdClk); #1;
    if (progMode && !l && !r1 && !r2) begin
      expRd = expSlot[expRdSel];
      expRdSel = (expRdSel + 1) % 4;
    end
    ldN = 1; rdEn1N = 1; rdEn2N = 1;
    check(req, int'(rdData), expRd);
  endtask

  initial begin : watchdog
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: defaults after a programming-mode reset
    doReset(1'b0);
    #1;
    checkOffsets("R1");
    check("R1", int'(rdData), 0);

    // R2/R3/R4/R6/R7: wrapping writes with breaks and disabled cycles
    for (int i = 0; i < 10; i++) begin
      int d = (i * 53 + 9'h1F0) % 512;
      doWrite(1'b0, 1'b0, d, (i < 4) ? "R2" : (i == 4 ? "R3" : "R6"));
      if (i == 1) doWrite(1'b1, 1'b0, 9'h0AA, "R7");  // normal buffer write
      if (i == 2) doWrite(1'b0, 1'b1, 9'h155, "R7");  // enable high
      if (i == 5) doWrite(1'b1, 1'b1, 9'h0FF, "R4");  // idle, position held
    end

    // R5/R6/R8: read back the ring, with disabled reads mixed in
    for (int k = 0; k < 9; k++) begin
      doRead(1'b0, 1'b0, 1'b0, (expRdSel % 2) ? "R6" : "R5");
      if (k == 2) doRead(1'b0, 1'b1, 1'b0, "R8");
      if (k == 4) doRead(1'b0, 1'b0, 1'b1, "R8");
      if (k == 6) doRead(1'b1, 1'b0, 1'b0, "R8");
    end

    // R4/R5: reset returns both positions to the empty-low slot
    doReset(1'b0);
    #1;
    checkOffsets("R1");
    doRead(1'b0, 1'b0, 1'b0, "R5");
    doWrite(1'b0, 1'b0, 9'h033, "R4");
    doWrite(1'b0, 1'b0, 9'h1FF, "R6");
    doRead(1'b0, 1'b0, 1'b0, "R5");

    // R9: two-enable mode ignores everything
    doReset(1'b1);
    for (int j = 0; j < 5; j++) doWrite(1'b0, 1'b0, 9'h100 + j, "R9");
    for (int j = 0; j < 3; j++) doRead(1'b0, 1'b0, 1'b0, "R9");
    check("R9", int'(offN), 7);
    check("R9", int'(rdData), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule